// File: doc/BRIEF.md
# Modem Line Change Detector

This block observes the four modem-control inputs of a serial port: carrier detect, ring indicator, data-set ready and clear-to-send. It records each line event in a sticky flag that software picks up through the status register. The inputs are asynchronous, so each one first passes through a multi-flop synchronizer. An edge detector then compares each synchronized sample with the sample before it. Carrier detect, data-set ready and clear-to-send raise their flag on a change in either direction. The ring indicator raises its flag only when the line goes from low to high.

The register decode around the block asserts a one-cycle read strobe while the status register is being read. In that cycle the block presents an 8-bit read value. The lower nibble holds the four change flags and the upper nibble mirrors the current synchronized line levels. All four flags clear on the clock edge that ends the read, unless a new event arrives in that same cycle. An interrupt request stays high while any flag is set.

Top module: `modem_delta_monitor`

## Requirements
- R1: While reset is asserted, the flag nibble `status_o[3:0]` reads 0 and `irq_o` is low.
- R2: Flag bit 3 (carrier detect, input bit 3) sets when the synchronized carrier-detect level changes in either direction.
- R3: Flag bit 2 (ring indicator, input bit 2) sets only when the synchronized ring level goes from 0 to 1. A 1-to-0 transition leaves it unchanged.
- R4: Flag bit 1 (data-set ready, input bit 1) and flag bit 0 (clear-to-send, input bit 0) each set on any level change of their own line.
- R5: A read cycle (`status_rd` high) returns the current flags. On the following clock edge every flag that had no new event is cleared.
- R6: An event detected in the same cycle as a read leaves its flag set after that read.
- R7: Each input passes through two synchronizer flops. A change driven before clock edge k appears in the level nibble after edge k+1 and in the flag nibble after edge k+2.
- R8: The first synchronized sample after reset sets no flag, even when a line is already high as reset ends.
- R9: `status_o[7:4]` carries the synchronized levels: bit 4 clear-to-send, bit 5 data-set ready, bit 6 ring indicator, bit 7 carrier detect.
- R10: `irq_o` is high exactly while at least one flag bit is set.
- R11: A set flag stays set through further line changes, including a return to the original level, until a read clears it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| modem_in | input | 4 | Raw modem lines: [3] carrier detect, [2] ring, [1] data-set ready, [0] clear-to-send |
| status_rd | input | 1 | One-cycle strobe marking a read of the status register |
| status_o | output | 8 | Read value: [7:4] synchronized levels, [3:0] change flags |
| irq_o | output | 1 | Interrupt request, high while any flag is set |

## Verification
Directed sequences drive each line low and back high. The first half of each pair tells the any-change lines apart from the rising-only ring line, and the second half confirms that a flag already set does not toggle off. One line held high through reset checks that startup gives no false event. A read timed onto the exact cycle of a detected change checks that the collision keeps the flag. Random single-bit flips mixed with random reads then check, cycle by cycle, the flag nibble, the level mirror and the interrupt against a bench model of the delay and the edge rules.

// File: rtl/msd_pkg.sv
package msd_pkg;
   localparam int NUM_LINES = 4;
   localparam int LN_CTS = 0;
   localparam int LN_DSR = 1;
   localparam int LN_RI  = 2;
   localparam int LN_DCD = 3;

   typedef enum logic {
      EDGE_ANY  = 1'b0,
      EDGE_RISE = 1'b1
   } edge_kind_e;
endpackage

// File: rtl/msd_sync.sv
module msd_sync #(
   parameter int WIDTH  = 4,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout,
   output logic             dout_vld
);
   localparam int LAST = STAGES - 1;

   if (STAGES < 2) begin : g_bad_stages
      $error("msd_sync: STAGES must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("msd_sync: WIDTH must be positive");
   end

   logic [WIDTH-1:0] stg [STAGES];
   logic [STAGES-1:0] vld;

   for (genvar k = 0; k < STAGES; k++) begin : g_stage
      if (k == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               stg[0] <= '0;
               vld[0] <= 1'b0;
            end else begin
               stg[0] <= din;
               vld[0] <= 1'b1;
            end
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               stg[k] <= '0;
               vld[k] <= 1'b0;
            end else begin
               stg[k] <= stg[k-1];
               vld[k] <= vld[k-1];
            end
         end
      end
   end

   assign dout     = stg[LAST];
   assign dout_vld = vld[LAST];
endmodule

// File: rtl/msd_event.sv
module msd_event #(
   parameter msd_pkg::edge_kind_e KIND = msd_pkg::EDGE_ANY
) (
   input  logic clk,
   input  logic rst_n,
   input  logic smp,
   input  logic smp_vld,
   output logic evt
);
   logic prev_q;
   logic prev_vld_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q     <= 1'b0;
         prev_vld_q <= 1'b0;
      end else begin
         prev_q     <= smp;
         prev_vld_q <= smp_vld;
      end
   end

   if (KIND == msd_pkg::EDGE_RISE) begin : g_rise
      assign evt = prev_vld_q & smp & ~prev_q;
   end else begin : g_any
      assign evt = prev_vld_q & (smp ^ prev_q);
   end
endmodule

// File: rtl/msd_flag.sv
module msd_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic evt,
   input  logic clr,
   output logic flag_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_o <= 1'b0;
      else        flag_o <= (flag_o & ~clr) | evt;
   end

   // R5
   read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !evt) |=> !flag_o);
   // R6
   event_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      evt |=> flag_o);
   // R11
   sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_o && !clr) |=> flag_o);
   // R2
   no_spurious_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!flag_o && !evt) |=> !flag_o);
endmodule

// File: rtl/modem_delta_monitor.sv
module modem_delta_monitor #(
   parameter int                             SYNC_STAGES    = 2,
   parameter logic [msd_pkg::NUM_LINES-1:0]  RISE_ONLY_MASK = 4'b0100
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [3:0] modem_in,
   input  logic       status_rd,
   output logic [7:0] status_o,
   output logic       irq_o
);
   import msd_pkg::*;

   localparam int NL = NUM_LINES;

   logic [NL-1:0] level;
   logic          level_vld;
   logic [NL-1:0] evt;
   logic [NL-1:0] delta;

   msd_sync #(
      .WIDTH (NL),
      .STAGES(SYNC_STAGES)
   ) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .din     (modem_in),
      .dout    (level),
      .dout_vld(level_vld)
   );

   for (genvar i = 0; i < NL; i++) begin : g_line
      localparam edge_kind_e KIND = RISE_ONLY_MASK[i] ? EDGE_RISE : EDGE_ANY;

      msd_event #(.KIND(KIND)) u_evt (
         .clk    (clk),
         .rst_n  (rst_n),
         .smp    (level[i]),
         .smp_vld(level_vld),
         .evt    (evt[i])
      );

      msd_flag u_flag (
         .clk   (clk),
         .rst_n (rst_n),
         .evt   (evt[i]),
         .clr   (status_rd),
         .flag_o(delta[i])
      );
   end

   assign status_o = {level, delta};
   assign irq_o    = |delta;

   if (RISE_ONLY_MASK[LN_RI]) begin : g_ri_chk
      // R3
      ri_rise_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(delta[LN_RI]) |-> ($past(level[LN_RI]) && !$past(level[LN_RI], 2)));
   end
endmodule

// File: tb/tb_modem_delta_monitor.sv
module tb_modem_delta_monitor;
   logic       clk = 1'b0;
   logic       rst_n;
   logic [3:0] line;
   logic       rd;
   logic [7:0] status;
   logic       irq;

   int    total = 0;
   int    bad   = 0;
   string tag;

   logic [3:0] m_s0, m_s1, m_prev, m_flags;
   logic       m_v0, m_v1, m_pv;

   always #5 clk = ~clk;

   modem_delta_monitor dut (
      .clk      (clk),
      .rst_n    (rst_n),
      .modem_in (line),
      .status_rd(rd),
      .status_o (status),
      .irq_o    (irq)
   );

   // lines 3,1,0 flag any change; line 2 flags only a rise
   function automatic logic [3:0] event_of(input logic [3:0] cur, input logic [3:0] prv,
                                           input logic ok);
      if (!ok) return 4'h0;
      return ((cur ^ prv) & 4'b1011) | (cur & ~prv & 4'b0100);
   endfunction

   task automatic chk(input string t, input logic [7:0] act, input logic [7:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h at %0t", t, act, exp, $time);
      end
   endtask

   task automatic step(input logic [3:0] ln, input logic r);
      logic [3:0] ev;
      line = ln;
      rd   = r;
      @(posedge clk);
      ev      = event_of(m_s1, m_prev, m_pv);
      m_flags = (m_flags & ~{4{r}}) | ev;
      m_prev  = m_s1;
      m_pv    = m_v1;
      m_s1    = m_s0;
      m_v1    = m_v0;
      m_s0    = ln;
      m_v0    = 1'b1;
      @(negedge clk);
      chk(tag, {4'h0, status[3:0]}, {4'h0, m_flags});
      chk("R9", {4'h0, status[7:4]}, {4'h0, m_s1});
      chk("R10", {7'h0, irq}, {7'h0, |m_flags});
   endtask

   initial begin
      #2000000;
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [3:0] ln;
      void'($urandom(32'd1234));
      rst_n = 1'b0; line = 4'hF; rd = 1'b0;
      m_s0 = 0; m_s1 = 0; m_prev = 0; m_flags = 0;
      m_v0 = 0; m_v1 = 0; m_pv = 0;
      repeat (3) @(negedge clk);
      chk("R1", {4'h0, status[3:0]}, 8'h00);
      chk("R1", {7'h0, irq}, 8'h00);
      rst_n = 1'b1;

      // R8: lines already high as reset ends
      tag = "R8";
      repeat (5) step(4'hF, 1'b0);

      // R2 then R11 then R5
      tag = "R2";
      repeat (4) step(4'h7, 1'b0);
      tag = "R11";
      repeat (4) step(4'hF, 1'b0);
      tag = "R5";
      step(4'hF, 1'b1);
      repeat (2) step(4'hF, 1'b0);

      // R3: fall ignored, rise flagged
      tag = "R3";
      repeat (4) step(4'hB, 1'b0);
      repeat (4) step(4'hF, 1'b0);
      step(4'hF, 1'b1);
      step(4'hF, 1'b0);

      // R4: DSR and CTS
      tag = "R4";
      repeat (4) step(4'hE, 1'b0);
      repeat (4) step(4'hC, 1'b0);
      step(4'hC, 1'b1);
      step(4'hC, 1'b0);

      // R7: latency of one change
      tag = "R7";
      repeat (4) step(4'hD, 1'b0);
      step(4'hD, 1'b1);
      step(4'hD, 1'b0);

      // R6: read lands on the event cycle
      tag = "R6";
      step(4'h5, 1'b0);
      step(4'h5, 1'b0);
      step(4'h5, 1'b1);
      step(4'h5, 1'b0);
      step(4'h5, 1'b1);
      step(4'h5, 1'b0);

      tag = "R2 R3 R4 R5 R6";
      ln = 4'h5;
      for (int n = 0; n < 400; n++) begin
         if ($urandom % 3 == 0) ln = ln ^ (4'h1 << ($urandom % 4));
         step(ln, ($urandom % 4) == 0);
      end

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule